// File: doc/BRIEF.md
# Read-After-Write Forward and Merge Unit

This unit sits on the read request path of a memory controller, between the read packetizer and the memory command queue. Every read request carries an address and a read ID. The pending write pool is an external block that looks up the request address in the same cycle and returns three things: a hit flag, the buffered write data, and a per-byte enable mask. The unit uses that answer to choose one of three ways to serve the read.

When the pool holds every byte of the address, the unit returns the buffered write data directly as the response and sends nothing to memory. When the pool holds only some of the bytes, the unit sends a memory read. It also stores the pool's data, mask and the read ID in a small table of merge slots. When memory answers, it overlays the stored write bytes onto the returned data. When the pool has nothing for the address, the read goes to memory as it is, and the returned data is passed on untouched.

All three kinds of result leave through one registered response port toward the reorder stage. Each response carries the original read ID and a kind code.

Top module: `rd_hazard_unit`

## Requirements
- R1: After reset `rs_valid` and `mc_valid` are low. With no request pending, `rq_ready` follows `mc_ready`.
- R2: A request whose lookup reports a hit with all byte enables set is a full hit. It drives `mc_valid` low and is accepted unless a memory return is present. In the cycle after acceptance, the response has `rs_kind`=1, the pool data and the request ID.
- R3: A request whose lookup reports a hit with at least one byte enable clear is a partial hit. It raises `mc_valid` with `mc_addr` equal to the request address. `mc_tag` has bit IW set and the lowest-numbered free merge slot in its low bits.
- R4: A memory return whose tag has bit IW set produces a response in the next cycle. It has `rs_kind`=2 and the ID stored in that slot. Byte i of the data is stored write byte i where stored enable bit i is 1, and returned memory byte i elsewhere. The slot becomes free at that edge.
- R5: A request that misses the pool raises `mc_valid` with the request address and `mc_tag` = {0, request ID}. A memory return whose tag has bit IW clear produces a response in the next cycle. It has `rs_kind`=0, ID equal to the tag's low IW bits, and the returned data unchanged.
- R6: While all ENTRIES merge slots are occupied, a partial-hit request sees `rq_ready` and `mc_valid` low. Misses and full hits are still accepted.
- R7: When a memory return and a full-hit request are present in the same cycle, the request is held off with `rq_ready` low. The response carries the memory-return result.
- R8: While `mc_ready` is low, miss and partial-hit requests are not accepted (`rq_ready` low). Full hits are unaffected.
- R9: A slot freed by a merge return can be allocated again by a later partial hit.
- R10: The write data and mask used in a merge are the values the pool presented when the request was accepted. Later changes on the lookup inputs have no effect on the merge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rq_valid | input | 1 | Read request present |
| rq_ready | output | 1 | Read request accepted this cycle when high with rq_valid |
| rq_addr | input | AW | Read request address |
| rq_id | input | IW | Read request ID |
| pl_hit | input | 1 | Pool lookup found a pending write for rq_addr |
| pl_data | input | DW | Pending write data from the pool |
| pl_be | input | DW/8 | Pending write byte enables from the pool |
| mc_valid | output | 1 | Memory read command present |
| mc_ready | input | 1 | Memory command queue can take a command |
| mc_addr | output | AW | Memory read address |
| mc_tag | output | IW+1 | Command tag: bit IW = merge, low bits = slot or read ID |
| mr_valid | input | 1 | Memory return present (always taken) |
| mr_tag | input | IW+1 | Tag echoed from the command |
| mr_data | input | DW | Memory return data |
| rs_valid | output | 1 | Response to the reorder stage present |
| rs_kind | output | 2 | 0 = memory passthrough, 1 = forwarded, 2 = merged |
| rs_id | output | IW | Read ID of the response |
| rs_data | output | DW | Response data |

## Verification
The memory command outputs and `rq_ready` are combinational, so they are checked one time unit after the inputs are driven on the falling edge. The checks run before the rising edge that would accept the request. A forwarded response is due one rising edge after acceptance, and a merged or passthrough response is due one rising edge after the memory return is presented. The bench samples `rs_*` on the falling edge that follows that rising edge. Slot numbers are predicted from the lowest-free rule, and merged words are computed in the bench from the captured bytes and the returned memory word.

// File: rtl/rd_hazard_pkg.sv
package rd_hazard_pkg;

  typedef enum logic [1:0] {
    KIND_MEM   = 2'd0,
    KIND_FWD   = 2'd1,
    KIND_MERGE = 2'd2
  } rs_kind_e;

endpackage

// File: rtl/rdh_slot_pick.sv
// Lowest-index free slot finder.
module rdh_slot_pick #(
  parameter int N  = 4,
  parameter int SW = 2
) (
  input  logic [N-1:0]  busy,
  output logic          found,
  output logic [SW-1:0] idx
);

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        found = 1'b1;
        idx   = SW'(i);
      end
    end
  end

endmodule

// File: rtl/rdh_byte_merge.sv
// Per-byte overlay of captured write bytes onto memory data.
module rdh_byte_merge #(
  parameter int BW = 4
) (
  input  logic [BW*8-1:0] wr_data,
  input  logic [BW-1:0]   wr_be,
  input  logic [BW*8-1:0] mem_data,
  output logic [BW*8-1:0] out_data
);

  for (genvar b = 0; b < BW; b++) begin : g_byte
    assign out_data[b*8 +: 8] = wr_be[b] ? wr_data[b*8 +: 8] : mem_data[b*8 +: 8];
  end

endmodule

// File: rtl/rdh_merge_table.sv
// Storage for captured partial-hit entries awaiting memory data.
module rdh_merge_table #(
  parameter int ENTRIES = 4,
  parameter int IW      = 4,
  parameter int DW      = 32,
  localparam int BW     = DW / 8,
  localparam int SW     = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alloc_en,
  input  logic [SW-1:0]      alloc_idx,
  input  logic [IW-1:0]      alloc_id,
  input  logic [DW-1:0]      alloc_data,
  input  logic [BW-1:0]      alloc_be,
  input  logic               rel_en,
  input  logic [SW-1:0]      rel_idx,
  output logic [ENTRIES-1:0] busy,
  output logic [IW-1:0]      rd_id,
  output logic [DW-1:0]      rd_data,
  output logic [BW-1:0]      rd_be
);

  logic [ENTRIES-1:0] busy_q, busy_d;
  logic [IW-1:0]      id_q   [ENTRIES];
  logic [DW-1:0]      data_q [ENTRIES];
  logic [BW-1:0]      be_q   [ENTRIES];
  logic [ENTRIES-1:0] load;

  always_comb begin
    busy_d = busy_q;
    load   = '0;
    if (rel_en) begin
      busy_d[rel_idx] = 1'b0;
    end
    if (alloc_en) begin
      busy_d[alloc_idx] = 1'b1;
      load[alloc_idx]   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= '0;
    end else begin
      busy_q <= busy_d;
    end
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    always_ff @(posedge clk) begin
      if (load[e]) begin
        id_q[e]   <= alloc_id;
        data_q[e] <= alloc_data;
        be_q[e]   <= alloc_be;
      end
    end
  end

  assign busy    = busy_q;
  assign rd_id   = id_q[rel_idx];
  assign rd_data = data_q[rel_idx];
  assign rd_be   = be_q[rel_idx];

endmodule

// File: rtl/rdh_resp_reg.sv
// Response register toward the reorder stage; memory return wins.
module rdh_resp_reg
  import rd_hazard_pkg::*;
#(
  parameter int IW = 4,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mem_en,
  input  rs_kind_e      mem_kind,
  input  logic [IW-1:0] mem_id,
  input  logic [DW-1:0] mem_data,
  input  logic          fwd_en,
  input  logic [IW-1:0] fwd_id,
  input  logic [DW-1:0] fwd_data,
  output logic          rs_valid,
  output logic [1:0]    rs_kind,
  output logic [IW-1:0] rs_id,
  output logic [DW-1:0] rs_data
);

  logic          valid_q, valid_d;
  rs_kind_e      kind_q, kind_d;
  logic [IW-1:0] id_q, id_d;
  logic [DW-1:0] data_q, data_d;
  logic          load;

  always_comb begin
    valid_d = mem_en | fwd_en;
    load    = valid_d;
    if (mem_en) begin
      kind_d = mem_kind;
      id_d   = mem_id;
      data_d = mem_data;
    end else begin
      kind_d = KIND_FWD;
      id_d   = fwd_id;
      data_d = fwd_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      kind_q <= kind_d;
      id_q   <= id_d;
      data_q <= data_d;
    end
  end

  assign rs_valid = valid_q;
  assign rs_kind  = kind_q;
  assign rs_id    = id_q;
  assign rs_data  = data_q;

endmodule

// File: rtl/rd_hazard_unit.sv
module rd_hazard_unit
  import rd_hazard_pkg::*;
#(
  parameter int AW      = 16,
  parameter int IW      = 4,
  parameter int DW      = 32,
  parameter int ENTRIES = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rq_valid,
  output logic            rq_ready,
  input  logic [AW-1:0]   rq_addr,
  input  logic [IW-1:0]   rq_id,
  input  logic            pl_hit,
  input  logic [DW-1:0]   pl_data,
  input  logic [DW/8-1:0] pl_be,
  output logic            mc_valid,
  input  logic            mc_ready,
  output logic [AW-1:0]   mc_addr,
  output logic [IW:0]     mc_tag,
  input  logic            mr_valid,
  input  logic [IW:0]     mr_tag,
  input  logic [DW-1:0]   mr_data,
  output logic            rs_valid,
  output logic [1:0]      rs_kind,
  output logic [IW-1:0]   rs_id,
  output logic [DW-1:0]   rs_data
);

  localparam int BW = DW / 8;
  localparam int SW = $clog2(ENTRIES);

  logic               full_hit, part_hit, slot_ok;
  logic               slot_free;
  logic [SW-1:0]      free_idx;
  logic [ENTRIES-1:0] slot_busy;
  logic               accept, fwd_fire, alloc_fire;
  logic [IW-1:0]      slot_field;
  logic               ret_merge;
  logic [SW-1:0]      ret_idx;
  logic [IW-1:0]      tbl_id;
  logic [DW-1:0]      tbl_data, merged;
  logic [BW-1:0]      tbl_be;
  logic [IW-1:0]      mem_id;
  logic [DW-1:0]      mem_word;
  rs_kind_e           mem_kind;

  // Request classification and handshakes
  always_comb begin
    full_hit   = pl_hit & (&pl_be);
    part_hit   = pl_hit & ~(&pl_be);
    slot_ok    = ~part_hit | slot_free;
    mc_valid   = rq_valid & ~full_hit & slot_ok;
    rq_ready   = full_hit ? ~mr_valid : (mc_ready & slot_ok);
    accept     = rq_valid & rq_ready;
    fwd_fire   = accept & full_hit;
    alloc_fire = accept & part_hit;
    slot_field = '0;
    slot_field[SW-1:0] = free_idx;
    mc_addr    = rq_addr;
    mc_tag     = part_hit ? {1'b1, slot_field} : {1'b0, rq_id};
  end

  // Memory return decode
  always_comb begin
    ret_merge = mr_tag[IW];
    ret_idx   = mr_tag[SW-1:0];
    if (ret_merge) begin
      mem_kind = KIND_MERGE;
      mem_id   = tbl_id;
      mem_word = merged;
    end else begin
      mem_kind = KIND_MEM;
      mem_id   = mr_tag[IW-1:0];
      mem_word = mr_data;
    end
  end

  rdh_slot_pick #(.N(ENTRIES), .SW(SW)) u_pick (
    .busy  (slot_busy),
    .found (slot_free),
    .idx   (free_idx)
  );

  rdh_merge_table #(.ENTRIES(ENTRIES), .IW(IW), .DW(DW)) u_table (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_en   (alloc_fire),
    .alloc_idx  (free_idx),
    .alloc_id   (rq_id),
    .alloc_data (pl_data),
    .alloc_be   (pl_be),
    .rel_en     (mr_valid & ret_merge),
    .rel_idx    (ret_idx),
    .busy       (slot_busy),
    .rd_id      (tbl_id),
    .rd_data    (tbl_data),
    .rd_be      (tbl_be)
  );

  rdh_byte_merge #(.BW(BW)) u_merge (
    .wr_data  (tbl_data),
    .wr_be    (tbl_be),
    .mem_data (mr_data),
    .out_data (merged)
  );

  rdh_resp_reg #(.IW(IW), .DW(DW)) u_resp (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_en   (mr_valid),
    .mem_kind (mem_kind),
    .mem_id   (mem_id),
    .mem_data (mem_word),
    .fwd_en   (fwd_fire),
    .fwd_id   (rq_id),
    .fwd_data (pl_data),
    .rs_valid (rs_valid),
    .rs_kind  (rs_kind),
    .rs_id    (rs_id),
    .rs_data  (rs_data)
  );

endmodule

// File: rtl/rd_hazard_chk.sv
module rd_hazard_chk #(
  parameter int AW      = 16,
  parameter int IW      = 4,
  parameter int DW      = 32,
  parameter int ENTRIES = 4,
  localparam int SW     = $clog2(ENTRIES)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rq_valid,
  input logic               rq_ready,
  input logic [AW-1:0]      rq_addr,
  input logic [IW-1:0]      rq_id,
  input logic               pl_hit,
  input logic [DW/8-1:0]    pl_be,
  input logic               mc_valid,
  input logic               mc_ready,
  input logic [AW-1:0]      mc_addr,
  input logic [IW:0]        mc_tag,
  input logic               mr_valid,
  input logic [IW:0]        mr_tag,
  input logic               rs_valid,
  input logic [1:0]         rs_kind,
  input logic [IW-1:0]      rs_id,
  input logic [ENTRIES-1:0] slot_busy
);

  // R2: full hit never goes to memory
  p_fwd_no_mem_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_valid && pl_hit && (&pl_be)) |-> !mc_valid);

  // R2: accepted full hit answers next cycle
  p_fwd_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_valid && rq_ready && pl_hit && (&pl_be)) |=>
      (rs_valid && rs_kind == 2'd1 && rs_id == $past(rq_id)));

  // R3: partial hit command targets a free slot
  p_slot_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_valid && mc_tag[IW]) |-> !slot_busy[mc_tag[SW-1:0]]);

  // R4: merge return answers next cycle and frees its slot
  p_merge_resp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mr_valid && mr_tag[IW]) |=>
      (rs_valid && rs_kind == 2'd2 && !slot_busy[$past(mr_tag[SW-1:0])]));

  // R5: miss passes address and ID to memory
  p_miss_tag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_valid && !pl_hit) |-> (mc_tag == {1'b0, rq_id} && mc_addr == rq_addr));

  // R6: no partial hit accepted with a full table
  p_table_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((&slot_busy) && rq_valid && pl_hit && !(&pl_be)) |-> (!rq_ready && !mc_valid));

  // R7: memory return blocks a full hit
  p_prio_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mr_valid && rq_valid && pl_hit && (&pl_be)) |-> !rq_ready);

  // R8: memory backpressure holds memory-bound requests
  p_backpressure_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mc_ready && !(pl_hit && (&pl_be))) |-> !rq_ready);

  // R1: any response follows an accepted request or a return
  p_resp_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!mr_valid && !(rq_valid && rq_ready && pl_hit && (&pl_be))) |=> !rs_valid);

endmodule

bind rd_hazard_unit rd_hazard_chk #(.AW(AW), .IW(IW), .DW(DW), .ENTRIES(ENTRIES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rq_valid  (rq_valid),
  .rq_ready  (rq_ready),
  .rq_addr   (rq_addr),
  .rq_id     (rq_id),
  .pl_hit    (pl_hit),
  .pl_be     (pl_be),
  .mc_valid  (mc_valid),
  .mc_ready  (mc_ready),
  .mc_addr   (mc_addr),
  .mc_tag    (mc_tag),
  .mr_valid  (mr_valid),
  .mr_tag    (mr_tag),
  .rs_valid  (rs_valid),
  .rs_kind   (rs_kind),
  .rs_id     (rs_id),
  .slot_busy (slot_busy)
);

// File: tb/rd_hazard_unit_tb.sv
`timescale 1ns/1ps
module rd_hazard_unit_tb;

  localparam int AW = 16;
  localparam int IW = 4;
  localparam int DW = 32;
  localparam int ENTRIES = 4;
  localparam int BW = DW / 8;

  logic          clk, rst_n;
  logic          rq_valid, rq_ready;
  logic [AW-1:0] rq_addr;
  logic [IW-1:0] rq_id;
  logic          pl_hit;
  logic [DW-1:0] pl_data;
  logic [BW-1:0] pl_be;
  logic          mc_valid, mc_ready;
  logic [AW-1:0] mc_addr;
  logic [IW:0]   mc_tag;
  logic          mr_valid;
  logic [IW:0]   mr_tag;
  logic [DW-1:0] mr_data;
  logic          rs_valid;
  logic [1:0]    rs_kind;
  logic [IW-1:0] rs_id;
  logic [DW-1:0] rs_data;

  int checks = 0;
  int failures = 0;

  rd_hazard_unit #(.AW(AW), .IW(IW), .DW(DW), .ENTRIES(ENTRIES)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .rq_valid(rq_valid), .rq_ready(rq_ready), .rq_addr(rq_addr), .rq_id(rq_id),
    .pl_hit(pl_hit), .pl_data(pl_data), .pl_be(pl_be),
    .mc_valid(mc_valid), .mc_ready(mc_ready), .mc_addr(mc_addr), .mc_tag(mc_tag),
    .mr_valid(mr_valid), .mr_tag(mr_tag), .mr_data(mr_data),
    .rs_valid(rs_valid), .rs_kind(rs_kind), .rs_id(rs_id), .rs_data(rs_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] overlay(input logic [DW-1:0] w, input logic [BW-1:0] be,
                                            input logic [DW-1:0] m);
    logic [DW-1:0] r;
    for (int b = 0; b < BW; b++) r[b*8 +: 8] = be[b] ? w[b*8 +: 8] : m[b*8 +: 8];
    return r;
  endfunction

  task automatic idle();
    rq_valid = 1'b0; pl_hit = 1'b0; mr_valid = 1'b0; mc_ready = 1'b1;
  endtask

  task automatic drive_req(input logic [IW-1:0] id, input logic [AW-1:0] a, input logic hit,
                           input logic [DW-1:0] d, input logic [BW-1:0] be);
    rq_valid = 1'b1; rq_id = id; rq_addr = a; pl_hit = hit; pl_data = d; pl_be = be;
  endtask

  task automatic drive_ret(input logic [IW:0] tag, input logic [DW-1:0] d);
    mr_valid = 1'b1; mr_tag = tag; mr_data = d;
  endtask

  // advance one rising edge, land on the falling edge, clear strobes
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic expect_rs(input string req, input logic [1:0] kind, input logic [IW-1:0] id,
                           input logic [DW-1:0] d);
    check({req, " rs_valid"}, 64'(rs_valid), 64'd1);
    check({req, " rs_kind"}, 64'(rs_kind), 64'(kind));
    check({req, " rs_id"}, 64'(rs_id), 64'(id));
    check({req, " rs_data"}, 64'(rs_data), 64'(d));
  endtask

  task automatic t_reset();
    #1;
    check("R1 rs_valid after reset", 64'(rs_valid), 64'd0);
    check("R1 mc_valid after reset", 64'(mc_valid), 64'd0);
    check("R1 rq_ready idle", 64'(rq_ready), 64'd1);
    mc_ready = 1'b0; #1;
    check("R1 rq_ready follows mc_ready", 64'(rq_ready), 64'd0);
    mc_ready = 1'b1;
  endtask

  task automatic t_miss();
    drive_req(4'h3, 16'h1230, 1'b0, 32'hFFFF_FFFF, 4'h0); #1;
    check("R5 miss mc_valid", 64'(mc_valid), 64'd1);
    check("R5 miss mc_addr", 64'(mc_addr), 64'h1230);
    check("R5 miss mc_tag", 64'(mc_tag), 64'h03);
    check("R5 miss rq_ready", 64'(rq_ready), 64'd1);
    tick();
    check("R5 no response before return", 64'(rs_valid), 64'd0);
    drive_ret(5'h03, 32'hA5A5_0101);
    tick();
    expect_rs("R5 passthrough", 2'd0, 4'h3, 32'hA5A5_0101);
    tick();
    check("R5 single beat", 64'(rs_valid), 64'd0);
  endtask

  task automatic t_full();
    drive_req(4'h7, 16'h0040, 1'b1, 32'hDEAD_BEEF, 4'hF); #1;
    check("R2 full hit mc_valid low", 64'(mc_valid), 64'd0);
    check("R2 full hit rq_ready", 64'(rq_ready), 64'd1);
    tick();
    expect_rs("R2 forward", 2'd1, 4'h7, 32'hDEAD_BEEF);
  endtask

  task automatic t_partial();
    drive_req(4'h9, 16'h0080, 1'b1, 32'h1122_3344, 4'b0101); #1;
    check("R3 partial mc_valid", 64'(mc_valid), 64'd1);
    check("R3 partial mc_addr", 64'(mc_addr), 64'h0080);
    check("R3 partial mc_tag slot0", 64'(mc_tag), 64'h10);
    tick();
    check("R3 partial no early response", 64'(rs_valid), 64'd0);
    // R10: lookup inputs change before the return
    pl_data = 32'h0000_0000; pl_be = 4'hF; pl_hit = 1'b0;
    drive_ret(5'h10, 32'hAABB_CCDD);
    tick();
    expect_rs("R4 R10 merge", 2'd2, 4'h9, overlay(32'h1122_3344, 4'b0101, 32'hAABB_CCDD));
  endtask

  task automatic t_fill();
    logic [DW-1:0] wd [ENTRIES];
    logic [BW-1:0] wb [ENTRIES];
    for (int k = 0; k < ENTRIES; k++) begin
      wd[k] = 32'h0101_0101 * (k + 1);
      wb[k] = 4'(k + 1);
      drive_req(4'(k + 1), 16'(16'h0200 + k), 1'b1, wd[k], wb[k]); #1;
      check("R3 fill slot order", 64'(mc_tag), 64'({1'b1, 4'(k)}));
      tick();
    end
    drive_req(4'hE, 16'h0300, 1'b1, 32'h7777_7777, 4'b0011); #1;
    check("R6 full table rq_ready low", 64'(rq_ready), 64'd0);
    check("R6 full table mc_valid low", 64'(mc_valid), 64'd0);
    tick();
    check("R6 held request gives no response", 64'(rs_valid), 64'd0);
    drive_req(4'hC, 16'h0310, 1'b0, 32'h0, 4'h0); #1;
    check("R6 miss accepted with full table", 64'(rq_ready), 64'd1);
    tick();
    drive_req(4'hD, 16'h0320, 1'b1, 32'h5555_AAAA, 4'hF); #1;
    check("R6 full hit accepted with full table", 64'(rq_ready), 64'd1);
    tick();
    expect_rs("R6 forward with full table", 2'd1, 4'hD, 32'h5555_AAAA);
    drive_ret(5'h0C, 32'h0BAD_F00D);
    tick();
    expect_rs("R6 miss return", 2'd0, 4'hC, 32'h0BAD_F00D);
    drive_ret(5'h12, 32'hFEDC_BA98);
    tick();
    expect_rs("R4 merge slot2", 2'd2, 4'h3, overlay(wd[2], wb[2], 32'hFEDC_BA98));
    drive_req(4'hB, 16'h0330, 1'b1, 32'h9999_8888, 4'b1000); #1;
    check("R9 reuse freed slot2", 64'(mc_tag), 64'h12);
    check("R9 rq_ready after free", 64'(rq_ready), 64'd1);
    tick();
    wd[2] = 32'h9999_8888; wb[2] = 4'b1000;
    for (int k = 0; k < ENTRIES; k++) begin
      drive_ret({1'b1, 4'(k)}, 32'h3C3C_3C3C + k);
      tick();
      expect_rs("R4 drain merge", 2'd2, (k == 2) ? 4'hB : 4'(k + 1),
                overlay(wd[k], wb[k], 32'h3C3C_3C3C + k));
    end
  endtask

  task automatic t_prio();
    drive_ret(5'h05, 32'h1357_9BDF);
    drive_req(4'h6, 16'h0400, 1'b1, 32'h2468_ACE0, 4'hF); #1;
    check("R7 full hit blocked by return", 64'(rq_ready), 64'd0);
    tick();
    expect_rs("R7 return wins", 2'd0, 4'h5, 32'h1357_9BDF);
    drive_req(4'h6, 16'h0400, 1'b1, 32'h2468_ACE0, 4'hF); #1;
    check("R7 full hit after return", 64'(rq_ready), 64'd1);
    tick();
    expect_rs("R7 forward follows", 2'd1, 4'h6, 32'h2468_ACE0);
  endtask

  task automatic t_backpressure();
    drive_req(4'h8, 16'h0500, 1'b0, 32'h0, 4'h0); mc_ready = 1'b0; #1;
    check("R8 miss held", 64'(rq_ready), 64'd0);
    drive_req(4'h8, 16'h0500, 1'b1, 32'h0, 4'b0001); mc_ready = 1'b0; #1;
    check("R8 partial held", 64'(rq_ready), 64'd0);
    drive_req(4'hA, 16'h0510, 1'b1, 32'hCAFE_0001, 4'hF); mc_ready = 1'b0; #1;
    check("R8 full hit unaffected", 64'(rq_ready), 64'd1);
    tick();
    expect_rs("R8 forward under backpressure", 2'd1, 4'hA, 32'hCAFE_0001);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    idle();
    rq_id = '0; rq_addr = '0; pl_data = '0; pl_be = '0; mr_tag = '0; mr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_miss();
    t_full();
    t_partial();
    t_fill();
    t_prio();
    t_backpressure();
    repeat (2) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule